// File: doc/BRIEF.md
# DRAM Bank Open-Row and Bus Turnaround Tracker

This block stands between an in-order source of memory requests and the command side of a DRAM controller. Each request names a bank, a row, a column and a direction, and is offered through a valid/ready handshake. The block remembers which row each bank has open and how recently that bank was activated. From this it decides whether the head request is a page hit, a page miss or a bank conflict. It holds `req_ready` low until every timing rule for that request is met. Those rules are the per-bank row-cycle time and the asymmetric data-bus turnaround gaps.

Every accepted request is modelled as one data-bus transfer cycle. Cycles in which a request is waiting but cannot issue are idle bus cycles. The two counts, taken together, give the effective data rate as busy / (busy + idle) of the peak rate. Separate saturating counters also record hits, misses and conflicts.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset no bank is open, every counter reads zero, `req_ready` is high, and the first access to any bank is classified as a miss.
- R2: A request to the row already open in its bank is a hit (`acc_kind` = 0). It is not delayed by the row-cycle time, and hits in one direction issue on consecutive cycles.
- R3: A request to a closed bank, or to another row of a bank whose row-cycle time has run out, is a miss (`acc_kind` = 1) and makes that row the bank's open row.
- R4: A request to another row of a bank whose last activation was fewer than `TRC` cycles ago is a conflict (`acc_kind` = 2). It issues exactly `TRC` cycles after that activation, unless a turnaround gap holds it longer.
- R5: A write that follows a read issues no sooner than `T_RD2WR` (6) idle cycles after the read.
- R6: A read that follows a write issues no sooner than `T_WR2RD` (15) idle cycles after the write.
- R7: Banks are timed independently: an activation in one bank never delays a request to another bank.
- R8: Requests issue strictly in order, on a cycle with `req_valid` and `req_ready` both high. `acc_valid` and `acc_kind` report the issue in that same cycle, and `req_ready` is high in any cycle where no rule blocks the head request.
- R9: `busy_cnt` counts issued requests and saturates at its all-ones value.
- R10: `idle_cnt` counts cycles with `req_valid` high and `req_ready` low. It stays unchanged across a stream of hits in one direction.
- R11: `hit_cnt`, `miss_cnt` and `conflict_cnt` count issued requests of each class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head request present |
| req_ready | output | 1 | Head request may issue this cycle |
| req_bank | input | BANK_W | Bank of the head request |
| req_row | input | ROW_W | Row of the head request |
| req_col | input | COL_W | Column of the head request |
| req_wr | input | 1 | 1 = write, 0 = read |
| acc_valid | output | 1 | A request issues this cycle |
| acc_kind | output | 2 | Class of the issuing request: 0 hit, 1 miss, 2 conflict |
| acc_col | output | COL_W | Column of the issuing request |
| hit_cnt | output | CNT_W | Issued hits |
| miss_cnt | output | CNT_W | Issued misses |
| conflict_cnt | output | CNT_W | Issued conflicts |
| busy_cnt | output | CNT_W | Data-bus transfer cycles |
| idle_cnt | output | CNT_W | Stalled cycles with a request waiting |

## Verification
The hardest case to reach is a bank conflict whose row-cycle wait overlaps a pending read/write turnaround. In that case the class must still be conflict, while the issue cycle is set by whichever limit ends later. A random stream reaches it by using only three rows, four banks and occasional direction flips, with requests presented back to back. Directed runs cover conflict-only, all-hit and pure turnaround sequences. A second instance with 3-bit counters receives the same stimulus and reaches saturation.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_MISS     = 2'd1,
    KIND_CONFLICT = 2'd2
  } acc_kind_e;

  // Idle cycles required when the bus changes direction after prev_wr.
  function automatic int unsigned turn_need(input logic prev_wr,
                                            input int unsigned rd2wr,
                                            input int unsigned wr2rd);
    return prev_wr ? wr2rd : rd2wr;
  endfunction

  // Class of an issuing request: open-row match, else whether tRC held it.
  function automatic acc_kind_e classify(input logic row_match, input logic trc_held);
    if (row_match)     return KIND_HIT;
    else if (trc_held) return KIND_CONFLICT;
    else               return KIND_MISS;
  endfunction
endpackage

// File: rtl/dbt_bank_state.sv
module dbt_bank_state #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int TRC       = 20
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                act,
  input  logic [BANK_W-1:0]                   act_bank,
  input  logic [ROW_W-1:0]                    act_row,
  output logic [NUM_BANKS-1:0]                bank_open,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]     open_row,
  output logic [NUM_BANKS-1:0]                bank_busy
);
  localparam int TW = $clog2(TRC + 1);
  localparam logic [TW-1:0] TRC_LOAD = TW'(TRC - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] tmr;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        open_row[b]  <= '0;
        tmr          <= '0;
      end else if (act && act_bank == BANK_W'(b)) begin
        bank_open[b] <= 1'b1;
        open_row[b]  <= act_row;
        tmr          <= TRC_LOAD;
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end
    end
    assign bank_busy[b] = (tmr != '0);
  end
endmodule

// File: rtl/dbt_turnaround.sv
module dbt_turnaround #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             fire_wr,
  output logic             has_prev,
  output logic             last_wr,
  output logic [GAP_W-1:0] gap_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_prev <= 1'b0;
      last_wr  <= 1'b0;
      gap_cnt  <= '0;
    end else if (fire) begin
      has_prev <= 1'b1;
      last_wr  <= fire_wr;
      gap_cnt  <= '0;
    end else if (gap_cnt != '1) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dbt_stats.sv
module dbt_stats #(
  parameter int NUM_CNT = 5,
  parameter int CNT_W   = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CNT-1:0]                inc,
  output logic [NUM_CNT-1:0][CNT_W-1:0]     cnt
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                         cnt[i] <= '0;
      else if (inc[i] && cnt[i] != '1)    cnt[i] <= cnt[i] + 1'b1;
    end
  end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int TRC       = 20,
  parameter int T_RD2WR   = 6,
  parameter int T_WR2RD   = 15,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_wr,
  output logic              acc_valid,
  output logic [1:0]        acc_kind,
  output logic [COL_W-1:0]  acc_col,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic [CNT_W-1:0]  conflict_cnt,
  output logic [CNT_W-1:0]  busy_cnt,
  output logic [CNT_W-1:0]  idle_cnt
);
  import dbt_pkg::*;

  localparam int GAP_MAX = (T_WR2RD > T_RD2WR) ? T_WR2RD : T_RD2WR;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int NUM_CNT = 5;

  // Named internal events
  logic [NUM_BANKS-1:0]            bank_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
  logic [NUM_BANKS-1:0]            bank_busy;
  logic                            has_prev;
  logic                            last_wr;
  logic [GAP_W-1:0]                gap_cnt;
  logic                            row_match;
  logic                            trc_ok;
  logic                            turn_ok;
  logic                            fire;
  logic                            activate;
  logic                            stall;
  logic                            trc_held;
  acc_kind_e                       kind;
  logic [NUM_CNT-1:0]              stat_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]   stat_cnt;

  assign row_match = bank_open[req_bank] && (open_row[req_bank] == req_row);
  assign trc_ok    = row_match || !bank_busy[req_bank];
  assign turn_ok   = !has_prev || (req_wr == last_wr) ||
                     (32'(gap_cnt) >= turn_need(last_wr, T_RD2WR, T_WR2RD));
  assign req_ready = trc_ok && turn_ok;
  assign fire      = req_valid && req_ready;
  assign activate  = fire && !row_match;
  assign stall     = req_valid && !req_ready;

  // Remembers that the head request was held by the row-cycle limit.
  always_ff @(posedge clk) begin
    if (!rst_n)                    trc_held <= 1'b0;
    else if (fire)                 trc_held <= 1'b0;
    else if (req_valid && !trc_ok) trc_held <= 1'b1;
  end

  assign kind      = classify(row_match, trc_held);
  assign acc_valid = fire;
  assign acc_kind  = kind;
  assign acc_col   = req_col;

  dbt_bank_state #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .TRC(TRC)
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .act(activate), .act_bank(req_bank), .act_row(req_row),
    .bank_open(bank_open), .open_row(open_row), .bank_busy(bank_busy)
  );

  dbt_turnaround #(.GAP_W(GAP_W)) u_turn (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_wr(req_wr),
    .has_prev(has_prev), .last_wr(last_wr), .gap_cnt(gap_cnt)
  );

  assign stat_inc = {stall, fire,
                     fire && (kind == KIND_CONFLICT),
                     fire && (kind == KIND_MISS),
                     fire && (kind == KIND_HIT)};

  dbt_stats #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .inc(stat_inc), .cnt(stat_cnt)
  );

  assign hit_cnt      = stat_cnt[0];
  assign miss_cnt     = stat_cnt[1];
  assign conflict_cnt = stat_cnt[2];
  assign busy_cnt     = stat_cnt[3];
  assign idle_cnt     = stat_cnt[4];
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int GAP_W     = 4,
  parameter int T_RD2WR   = 6,
  parameter int T_WR2RD   = 15,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [BANK_W-1:0]    req_bank,
  input logic                 req_wr,
  input logic                 acc_valid,
  input logic [1:0]           acc_kind,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic                 has_prev,
  input logic                 last_wr,
  input logic [GAP_W-1:0]     gap_cnt,
  input logic [CNT_W-1:0]     busy_cnt,
  input logic [CNT_W-1:0]     idle_cnt
);
  AST_HIT_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'd0 |-> bank_open[req_bank]); // R2
  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind != 2'd0 |=> bank_open[$past(req_bank)]); // R3
  AST_TRC_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind != 2'd0 |-> !bank_busy[req_bank]); // R4
  AST_RD2WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && has_prev && !last_wr && req_wr |-> 32'(gap_cnt) >= T_RD2WR); // R5
  AST_WR2RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && has_prev && last_wr && !req_wr |-> 32'(gap_cnt) >= T_WR2RD); // R6
  AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && busy_cnt != '1 |=> busy_cnt == $past(busy_cnt) + 1'b1); // R9
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && idle_cnt != '1 |=> idle_cnt == $past(idle_cnt) + 1'b1); // R10
endmodule

bind dram_bank_tracker dbt_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .GAP_W(GAP_W),
  .T_RD2WR(T_RD2WR), .T_WR2RD(T_WR2RD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .req_wr(req_wr), .acc_valid(acc_valid), .acc_kind(acc_kind),
  .bank_open(bank_open), .bank_busy(bank_busy), .has_prev(has_prev),
  .last_wr(last_wr), .gap_cnt(gap_cnt), .busy_cnt(busy_cnt), .idle_cnt(idle_cnt)
);

// File: tb/dram_bank_tracker_tb.sv
module dram_bank_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int ROW_W = 8;
  localparam int COL_W = 6;
  localparam int TRC = 20;
  localparam int T_RD2WR = 6;
  localparam int T_WR2RD = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_wr = 1'b0;
  logic req_ready, acc_valid;
  logic [1:0] acc_kind;
  logic [COL_W-1:0] acc_col;
  logic [15:0] hit_cnt, miss_cnt, conflict_cnt, busy_cnt, idle_cnt;
  logic s_ready, s_valid;
  logic [1:0] s_kind;
  logic [COL_W-1:0] s_col;
  logic [2:0] s_hit, s_miss, s_conf, s_busy, s_idle;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .TRC(TRC),
    .T_RD2WR(T_RD2WR), .T_WR2RD(T_WR2RD), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wr(req_wr),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_col(acc_col),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .conflict_cnt(conflict_cnt),
    .busy_cnt(busy_cnt), .idle_cnt(idle_cnt));

  dram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .TRC(TRC),
    .T_RD2WR(T_RD2WR), .T_WR2RD(T_WR2RD), .CNT_W(3)) u_sat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(s_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wr(req_wr),
    .acc_valid(s_valid), .acc_kind(s_kind), .acc_col(s_col),
    .hit_cnt(s_hit), .miss_cnt(s_miss), .conflict_cnt(s_conf),
    .busy_cnt(s_busy), .idle_cnt(s_idle));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;

  // Bench model of bank and bus history
  bit m_open [NB];
  int m_row  [NB];
  int m_act  [NB];
  bit m_has_prev = 0;
  bit m_last_wr = 0;
  int m_last_issue = 0;
  int e_hit = 0, e_miss = 0, e_conf = 0, e_busy = 0, e_idle = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int gap_need(input bit prev_wr);
    return prev_wr ? T_WR2RD : T_RD2WR;
  endfunction

  // Presents one request at a falling edge and holds it until it issues.
  task automatic do_req(input int b, input int r, input bit w, input string tag);
    int p, waits, exp_issue, exp_wait, exp_kind, issue;
    bit hit;
    req_valid = 1'b1; req_bank = 2'(b); req_row = ROW_W'(r); req_wr = w;
    req_col = COL_W'($urandom);
    p = cyc;
    hit = m_open[b] && m_row[b] == r;
    exp_issue = p + 1;
    if (!hit && m_open[b]) exp_issue = max2(exp_issue, m_act[b] + TRC);
    if (m_has_prev && w != m_last_wr)
      exp_issue = max2(exp_issue, m_last_issue + gap_need(m_last_wr) + 1);
    exp_kind = hit ? 0 : ((m_open[b] && (p + 1 < m_act[b] + TRC)) ? 2 : 1);
    exp_wait = exp_issue - (p + 1);
    waits = 0;
    forever begin
      #1;
      if (req_ready || waits > 1000) break;
      waits++;
      @(negedge clk);
    end
    chk(acc_valid == 1'b1, "R8", "acc_valid with ready", acc_valid, 1);
    chk(acc_col == req_col, "R8", "acc_col", acc_col, req_col);
    chk(acc_kind == 2'(exp_kind), tag, "acc_kind", acc_kind, exp_kind);
    chk(waits == exp_wait, tag, "stall cycles", waits, exp_wait);
    @(negedge clk);
    issue = p + 1 + waits;
    if (!hit) begin m_open[b] = 1; m_row[b] = r; m_act[b] = issue; end
    m_has_prev = 1; m_last_wr = w; m_last_issue = issue;
    case (exp_kind) 0: e_hit++; 1: e_miss++; default: e_conf++; endcase
    e_busy++;
    e_idle += waits;
  endtask

  task automatic idle_gap(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_counts(input string tag);
    chk(hit_cnt == 16'(e_hit), "R11", {tag, " hit_cnt"}, hit_cnt, e_hit);
    chk(miss_cnt == 16'(e_miss), "R11", {tag, " miss_cnt"}, miss_cnt, e_miss);
    chk(conflict_cnt == 16'(e_conf), "R11", {tag, " conflict_cnt"}, conflict_cnt, e_conf);
    chk(busy_cnt == 16'(e_busy), "R9", {tag, " busy_cnt"}, busy_cnt, e_busy);
    chk(idle_cnt == 16'(e_idle), "R10", {tag, " idle_cnt"}, idle_cnt, e_idle);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int idle_before;
    void'($urandom(32'd4242));
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; m_act[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    req_bank = 2'd3; req_row = 8'd9; req_wr = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(busy_cnt == 0 && idle_cnt == 0 && hit_cnt == 0, "R1", "counters after reset",
        busy_cnt + idle_cnt + hit_cnt, 0);
    @(negedge clk);
    do_req(3, 9, 0, "R1");

    // All page hits, one direction: no idle cycles
    do_req(1, 5, 0, "R3");
    idle_before = e_idle;
    for (int i = 0; i < 12; i++) do_req(1, 5, 0, "R2");
    chk(idle_cnt == 16'(idle_before), "R10", "idle over all-hit stream", idle_cnt, idle_before);
    chk_counts("hits");

    // Turnaround gaps on an open row
    do_req(1, 5, 1, "R5");
    do_req(1, 5, 1, "R2");
    do_req(1, 5, 0, "R6");
    do_req(1, 5, 1, "R5");
    chk_counts("turn");

    // Every access conflicting: alternating rows in one bank
    for (int i = 0; i < 6; i++) do_req(0, (i % 2) + 1, 1, (i == 0) ? "R3" : "R4");
    chk_counts("conflict");

    // Independent banks: fresh activation in bank 2 right after bank 0
    do_req(0, 7, 1, "R4");
    do_req(2, 7, 1, "R7");
    do_req(3, 4, 1, "R7");
    do_req(0, 8, 1, "R4");
    // Row reopened after tRC has expired: a miss, not a conflict
    idle_gap(TRC + 2);
    do_req(2, 1, 1, "R3");
    chk_counts("banks");

    // Random addresses, occasional direction flips and gaps
    begin
      bit w = 0;
      for (int i = 0; i < 160; i++) begin
        if ($urandom % 6 == 0) w = ~w;
        if ($urandom % 5 == 0) idle_gap(int'($urandom % 4));
        do_req(int'($urandom % NB), int'($urandom % 3), w, "R8");
      end
    end
    idle_gap(1);
    chk_counts("random");

    // R9: narrow counters saturate at all-ones
    chk(s_busy == 3'd7, "R9", "busy saturation", s_busy, 7);
    chk(s_idle == 3'd7, "R10", "idle saturation", s_idle, 7);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule